// File: doc/BRIEF.md
# Real-Time Clock Calendar Update Engine

This block holds the time of day and the calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle 1 Hz tick from outside advances the whole set by one second in a single clock cycle. Every time, calendar and alarm byte is kept in one of two number formats, binary or BCD. The hour byte uses either 24-hour or 12-hour form. In 12-hour form, bit 7 of the hour byte is the afternoon flag.

A small register port lets a host set the clock. The host first sets the hold bit, which freezes updating, then writes the time fields and clears the hold bit. Three alarm bytes are compared with the freshly updated time. Any alarm byte of 0xC0 or above matches every value. The block can also make the two yearly daylight-saving hour changes by itself. It reports each update and each alarm match as a one-cycle pulse, and it raises an interrupt request for each pulse whose enable bit is set.

Top module: `rtc_calendar_core`

## Requirements
- R1: Register map on `addr`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 8 alarm seconds, 9 alarm minutes, 0xA alarm hours, 0xF control. Other addresses read 0. Writes to addresses 0–6 take effect only while hold is 1 and are dropped otherwise. Alarm and control bytes can be written at any time.
- R2: Control bit 0 is hold. While hold is 1, ticks are ignored: no time field changes and `upd_pulse` stays 0.
- R3: With hold at 0, each tick advances the time by exactly one second. The new values and a one-cycle `upd_pulse` appear in the cycle after the tick.
- R4: Seconds and minutes wrap from 59 to 0. In 24-hour form, hours wrap from 23 to 0. Day of week runs 1..7, with 1 for Sunday, and wraps from 7 to 1 when the day changes.
- R5: Day of month wraps to 1 after the month's last day. February has 29 days when the year is a multiple of 4. Month 12 is followed by month 1 and year+1, and year 99 is followed by 0.
- R6: Control bit 1 selects binary (1) or BCD (0) for every time, calendar and alarm byte.
- R7: Control bit 2 selects 24-hour form (1) or 12-hour form (0). In 12-hour form the hours run 12, 1, …, 11. Bit 7 of the hour byte is 1 for PM and flips on the step from 11 to 12. 12 AM is midnight.
- R8: With control bit 3 (daylight saving) at 1, on a Sunday with day of month 1–7 in April, 1:59:59 AM is followed by 3:00:00 AM.
- R9: With control bit 3 at 1, on a Sunday with day of month 25–31 in October, the first 1:59:59 AM is followed by 1:00:00 AM. The second 1:59:59 AM that day is followed by 2:00:00 AM.
- R10: A daylight-saving jump happens only if at least two ticks have advanced the time since hold was last 1.
- R11: `alm_pulse` is 1 in the cycle after an update whose new seconds, minutes and hours each equal the matching alarm byte, or whose alarm byte is 0xC0 or above.
- R12: `irq` is 1 exactly when `upd_pulse` is 1 and control bit 4 is set, or when `alm_pulse` is 1 and control bit 5 is set.
- R13: `sys_rst_n` clears control bit 4 only. `rtc_rst_n` clears control bit 5, the alarm bytes and the time fields, setting day of week, day of month and month to 1 and the rest to 0. Neither reset changes control bits 0–3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rtc_rst_n | input | 1 | Clock-domain reset, active low, asynchronous |
| sys_rst_n | input | 1 | Host-side reset, active low, clears update-interrupt enable |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| upd_pulse | output | 1 | One-cycle pulse after each update |
| alm_pulse | output | 1 | One-cycle pulse after an update that matches the alarm |
| irq | output | 1 | Gated interrupt request |

## Verification
A full 24-hour sweep in 12-hour BCD form checks every second. It separates errors in decimal carry, in the 12 to 1 hour order and in PM flipping. A three-hour binary 24-hour window across midnight checks the plain binary path. Eight years of day-by-day rollovers, half in BCD and half in binary, cover every month length, leap February, year change and weekday wrap. The daylight-saving cases vary the weekday, the week of the month, the month, the enable bit and how far before the trigger time the clock was loaded, so each condition is tested on its own. Alarm runs compare byte wildcards against an exact match.

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core #(
  parameter int unsigned CENTURY = 100
) (
  input  logic       clk,
  input  logic       rtc_rst_n,
  input  logic       sys_rst_n,
  input  logic       tick_1hz,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       upd_pulse,
  output logic       alm_pulse,
  output logic       irq
);
  localparam logic [6:0] YMAX = 7'(CENTURY - 1);
  localparam logic [3:0] A_SEC = 4'h0, A_MIN = 4'h1, A_HR = 4'h2, A_DOW = 4'h3,
                         A_DOM = 4'h4, A_MON = 4'h5, A_YR = 4'h6, A_ASEC = 4'h8,
                         A_AMIN = 4'h9, A_AHR = 4'hA, A_CTL = 4'hF;

  logic [7:0] sec_q, min_q, hour_q, dow_q, dom_q, mon_q, yr_q;
  logic [7:0] asec_q, amin_q, ahr_q;
  logic       hold_q, bin_q, h24_q, dse_q, uie_q, aie_q;
  logic [1:0] run_q;
  logic       fall_q;

  function automatic logic [6:0] dec(input logic [7:0] v, input logic bcd);
    logic [6:0] tens;
    tens = {3'd0, v[7:4]};
    return bcd ? tens * 7'd10 + {3'd0, v[3:0]} : v[6:0];
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] n, input logic bcd);
    logic [3:0] t, o;
    t = 4'(n / 7'd10);
    o = 4'(n % 7'd10);
    return bcd ? {t, o} : {1'b0, n};
  endfunction

  function automatic logic amatch(input logic [7:0] al, input logic [7:0] v);
    return (al[7:6] == 2'b11) || (al == v);
  endfunction

  wire bcd = !bin_q;
  wire step = tick_1hz && !hold_q;

  logic [6:0] s, m, h, hl, dw, d, mo, y;
  logic [6:0] ns, nm, nh, nd, ndw, nmo, ny, hm, hd, mlen;
  logic       at159, spring, fall_hit, new_day, match;
  logic [7:0] sec_n, min_n, hour_n, dow_n, dom_n, mon_n, yr_n;

  always_comb begin
    s  = dec(sec_q, bcd);
    m  = dec(min_q, bcd);
    dw = dec(dow_q, bcd);
    d  = dec(dom_q, bcd);
    mo = dec(mon_q, bcd);
    y  = dec(yr_q, bcd);
    hl = dec({1'b0, hour_q[6:0]}, bcd);
    if (h24_q) h = dec(hour_q, bcd);
    else       h = ((hl == 7'd12) ? 7'd0 : hl) + (hour_q[7] ? 7'd12 : 7'd0);

    case (mo)
      7'd2:                     mlen = (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  mlen = 7'd30;
      default:                  mlen = 7'd31;
    endcase

    at159    = dse_q && run_q == 2'd2 && dw == 7'd1 && h == 7'd1 && m == 7'd59 && s == 7'd59;
    spring   = at159 && mo == 7'd4 && d <= 7'd7;
    fall_hit = at159 && mo == 7'd10 && d >= 7'd25 && !fall_q;

    ns = s + 7'd1; nm = m; nh = h; nd = d; ndw = dw; nmo = mo; ny = y; new_day = 1'b0;
    if (s >= 7'd59) begin
      ns = 7'd0;
      nm = m + 7'd1;
      if (m >= 7'd59) begin
        nm = 7'd0;
        nh = h + 7'd1;
        if (h >= 7'd23) begin
          nh = 7'd0;
          new_day = 1'b1;
        end
      end
    end
    if (spring)   begin nh = 7'd3; nm = 7'd0; ns = 7'd0; end
    if (fall_hit) begin nh = 7'd1; nm = 7'd0; ns = 7'd0; end
    if (new_day) begin
      ndw = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
      if (d >= mlen) begin
        nd = 7'd1;
        if (mo >= 7'd12) begin
          nmo = 7'd1;
          ny  = (y >= YMAX) ? 7'd0 : y + 7'd1;
        end else nmo = mo + 7'd1;
      end else nd = d + 7'd1;
    end

    hm = (nh >= 7'd12) ? nh - 7'd12 : nh;
    hd = (hm == 7'd0) ? 7'd12 : hm;
    sec_n  = enc(ns, bcd);
    min_n  = enc(nm, bcd);
    hour_n = h24_q ? enc(nh, bcd) : {nh >= 7'd12, 7'(enc(hd, bcd))};
    dow_n  = enc(ndw, bcd);
    dom_n  = enc(nd, bcd);
    mon_n  = enc(nmo, bcd);
    yr_n   = enc(ny, bcd);
    match  = amatch(asec_q, sec_n) && amatch(amin_q, min_n) && amatch(ahr_q, hour_n);
  end

  always_ff @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      sec_q <= 8'd0; min_q <= 8'd0; hour_q <= 8'd0; dow_q <= 8'd1;
      dom_q <= 8'd1; mon_q <= 8'd1; yr_q <= 8'd0;
    end else if (hold_q) begin
      if (wr_en) begin
        case (addr)
          A_SEC: sec_q  <= wdata;
          A_MIN: min_q  <= wdata;
          A_HR:  hour_q <= wdata;
          A_DOW: dow_q  <= wdata;
          A_DOM: dom_q  <= wdata;
          A_MON: mon_q  <= wdata;
          A_YR:  yr_q   <= wdata;
          default: ;
        endcase
      end
    end else if (tick_1hz) begin
      sec_q <= sec_n; min_q <= min_n; hour_q <= hour_n; dow_q <= dow_n;
      dom_q <= dom_n; mon_q <= mon_n; yr_q <= yr_n;
    end
  end

  always_ff @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      asec_q <= 8'd0; amin_q <= 8'd0; ahr_q <= 8'd0; aie_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_ASEC) asec_q <= wdata;
      if (addr == A_AMIN) amin_q <= wdata;
      if (addr == A_AHR)  ahr_q  <= wdata;
      if (addr == A_CTL)  aie_q  <= wdata[5];
    end
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) uie_q <= 1'b0;
    else if (wr_en && addr == A_CTL) uie_q <= wdata[4];
  end

  always_ff @(posedge clk) begin
    if (wr_en && addr == A_CTL) {dse_q, h24_q, bin_q, hold_q} <= wdata[3:0];
  end

  always_ff @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      run_q <= 2'd0; fall_q <= 1'b0; upd_pulse <= 1'b0; alm_pulse <= 1'b0;
    end else begin
      upd_pulse <= step;
      alm_pulse <= step && match;
      if (hold_q) run_q <= 2'd0;
      else if (tick_1hz && run_q != 2'd2) run_q <= run_q + 2'd1;
      if (step) begin
        if (fall_hit) fall_q <= 1'b1;
        else if (new_day) fall_q <= 1'b0;
      end
    end
  end

  assign irq = (upd_pulse && uie_q) || (alm_pulse && aie_q);

  always_comb begin
    case (addr)
      A_SEC:  rdata = sec_q;
      A_MIN:  rdata = min_q;
      A_HR:   rdata = hour_q;
      A_DOW:  rdata = dow_q;
      A_DOM:  rdata = dom_q;
      A_MON:  rdata = mon_q;
      A_YR:   rdata = yr_q;
      A_ASEC: rdata = asec_q;
      A_AMIN: rdata = amin_q;
      A_AHR:  rdata = ahr_q;
      A_CTL:  rdata = {2'b00, aie_q, uie_q, dse_q, h24_q, bin_q, hold_q};
      default: rdata = 8'd0;
    endcase
  end

  // R2
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    hold_q && !wr_en |=> $stable(sec_q) && $stable(hour_q) && $stable(dom_q) && !upd_pulse);

  // R3
  upd_src_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    upd_pulse |-> $past(tick_1hz) && !$past(hold_q));

  // R1
  sec_change_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    !$stable(sec_q) |-> ($past(hold_q) ? $past(wr_en) : $past(tick_1hz)));

  // R11
  alm_upd_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    alm_pulse |-> upd_pulse);

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    !upd_pulse && !alm_pulse |-> !irq);
endmodule

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;
  logic clk = 1'b0, rtc_rst_n = 1'b0, sys_rst_n = 1'b0, tick_1hz = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00, rdata;
  logic upd_pulse, alm_pulse, irq;
  int checks = 0, fails = 0;

  rtc_calendar_core i_rtc_calendar_core (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #0.1; d = rdata;
  endtask

  task automatic ticks(input int n);
    tick_1hz = 1'b1;
    repeat (n) @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic load(input logic [7:0] ctl, input logic [7:0] h, mi, s, dw, d, mo, y);
    wreg(4'hF, ctl | 8'h01);
    wreg(4'h0, s); wreg(4'h1, mi); wreg(4'h2, h); wreg(4'h3, dw);
    wreg(4'h4, d); wreg(4'h5, mo); wreg(4'h6, y);
    wreg(4'hF, ctl & 8'hFE);
  endtask

  task automatic chk_time(input string tag, input logic [7:0] eh, em, es);
    logic [7:0] v;
    rd(4'h2, v); chk(tag, v, eh);
    rd(4'h1, v); chk(tag, v, em);
    rd(4'h0, v); chk(tag, v, es);
  endtask

  function automatic logic [7:0] be(input int n, input bit bin);
    return bin ? 8'(n) : 8'((n / 10) * 16 + n % 10);
  endfunction

  function automatic logic [7:0] bh12(input int h);
    int hh;
    hh = h % 12;
    if (hh == 0) hh = 12;
    return be(hh, 1'b0) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int dw, t;
    repeat (3) @(negedge clk);
    rtc_rst_n = 1'b1; sys_rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    rd(4'h0, v); chk("R13 sec reset", v, 8'h00);
    rd(4'h4, v); chk("R13 dom reset", v, 8'h01);
    rd(4'h5, v); chk("R13 mon reset", v, 8'h01);
    rd(4'h3, v); chk("R13 dow reset", v, 8'h01);
    rd(4'hF, v); chk("R13 enables reset", v[5:4], 2'b00);
    chk("R13 pulses reset", {upd_pulse, alm_pulse, irq}, 3'b000);

    // R13 reset selectivity
    wreg(4'hF, 8'h3F);
    wreg(4'h0, 8'h12);
    sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1;
    rd(4'hF, v); chk("R13 sys reset clears only bit4", v, 8'h2F);
    rd(4'h0, v); chk("R13 sys reset keeps time", v, 8'h12);
    wreg(4'hF, 8'h3F);
    rtc_rst_n = 1'b0; @(negedge clk); rtc_rst_n = 1'b1;
    rd(4'hF, v); chk("R13 rtc reset clears only bit5", v, 8'h1F);
    rd(4'h0, v); chk("R13 rtc reset clears time", v, 8'h00);

    // R2 hold, R3 single step, R1 write dropped when not held
    wreg(4'hF, 8'h07);
    wreg(4'h0, 8'd33);
    ticks(3);
    rd(4'h0, v); chk("R2 held seconds", v, 8'd33);
    chk("R2 no pulse when held", upd_pulse, 1'b0);
    wreg(4'hF, 8'h06);
    ticks(1);
    rd(4'h0, v); chk("R3 one second step", v, 8'd34);
    chk("R3 update pulse", upd_pulse, 1'b1);
    @(negedge clk);
    chk("R3 pulse one cycle", upd_pulse, 1'b0);
    wreg(4'h0, 8'd50);
    rd(4'h0, v); chk("R1 write ignored without hold", v, 8'd34);
    rd(4'h7, v); chk("R1 unmapped reads 0", v, 8'h00);

    // R7 R6 R4 full day, 12-hour BCD
    load(8'h00, 8'h12, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    tick_1hz = 1'b1;
    for (int k = 1; k <= 86400; k++) begin
      @(negedge clk);
      t = k % 86400;
      chk_time("R7 R6 12h BCD day sweep", bh12(t / 3600), be((t / 60) % 60, 1'b0), be(t % 60, 1'b0));
      chk("R3 pulse per tick", upd_pulse, 1'b1);
    end
    tick_1hz = 1'b0;

    // R4 R6 24-hour binary across midnight
    load(8'h06, 8'd22, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0);
    tick_1hz = 1'b1;
    for (int k = 1; k <= 10800; k++) begin
      @(negedge clk);
      t = (79200 + k) % 86400;
      chk_time("R4 24h binary sweep", 8'(t / 3600), 8'((t / 60) % 60), 8'(t % 60));
    end
    tick_1hz = 1'b0;

    // R5 R4 calendar sweep, BCD years 0-3, binary years 4-7
    dw = 1;
    for (int y = 0; y < 8; y++) begin
      bit bn;
      logic [7:0] ctl;
      bn = (y >= 4);
      ctl = bn ? 8'h06 : 8'h04;
      load(ctl, be(23, bn), be(59, bn), be(59, bn), be(dw, bn), be(1, bn), be(1, bn), be(y, bn));
      for (int mo = 1; mo <= 12; mo++) begin
        for (int d = 1; d <= mdays(mo, y); d++) begin
          int nd, nmo, ny;
          if (!(mo == 1 && d == 1)) begin
            wreg(4'hF, ctl | 8'h01);
            wreg(4'h0, be(59, bn)); wreg(4'h1, be(59, bn)); wreg(4'h2, be(23, bn));
            wreg(4'hF, ctl);
          end
          ticks(1);
          dw = dw % 7 + 1;
          if (d == mdays(mo, y)) begin
            nd = 1; nmo = (mo == 12) ? 1 : mo + 1; ny = (mo == 12) ? y + 1 : y;
          end else begin
            nd = d + 1; nmo = mo; ny = y;
          end
          rd(4'h4, v); chk("R5 day of month", v, be(nd, bn));
          rd(4'h5, v); chk("R5 month", v, be(nmo, bn));
          rd(4'h6, v); chk("R5 year", v, be(ny, bn));
          rd(4'h3, v); chk("R4 day of week", v, be(dw, bn));
          rd(4'h2, v); chk("R4 hour wraps to 0", v, 8'h00);
        end
      end
    end

    // R5 year 99 wraps to 0
    load(8'h06, 8'd23, 8'd59, 8'd59, 8'd7, 8'd31, 8'd12, 8'd99);
    ticks(1);
    rd(4'h6, v); chk("R5 year wrap", v, 8'd0);
    rd(4'h5, v); chk("R5 month wrap", v, 8'd1);
    rd(4'h3, v); chk("R4 dow 7 to 1", v, 8'd1);

    // R8 spring forward, binary 24h
    load(8'h0E, 8'd1, 8'd59, 8'd50, 8'd1, 8'd2, 8'd4, 8'd6);
    ticks(10); chk_time("R8 April first Sunday jump", 8'd3, 8'd0, 8'd0);
    load(8'h0E, 8'd1, 8'd59, 8'd50, 8'd2, 8'd2, 8'd4, 8'd6);
    ticks(10); chk_time("R8 not Sunday", 8'd2, 8'd0, 8'd0);
    load(8'h0E, 8'd1, 8'd59, 8'd50, 8'd1, 8'd9, 8'd4, 8'd6);
    ticks(10); chk_time("R8 second Sunday", 8'd2, 8'd0, 8'd0);
    load(8'h06, 8'd1, 8'd59, 8'd50, 8'd1, 8'd2, 8'd4, 8'd6);
    ticks(10); chk_time("R8 disabled", 8'd2, 8'd0, 8'd0);
    load(8'h08, 8'h01, 8'h59, 8'h50, 8'h01, 8'h02, 8'h04, 8'h06);
    ticks(10); chk_time("R8 R7 12h BCD jump", 8'h03, 8'h00, 8'h00);

    // R10 two prior updates
    load(8'h0E, 8'd1, 8'd59, 8'd58, 8'd1, 8'd2, 8'd4, 8'd6);
    ticks(2); chk_time("R10 one prior update no jump", 8'd2, 8'd0, 8'd0);
    load(8'h0E, 8'd1, 8'd59, 8'd57, 8'd1, 8'd2, 8'd4, 8'd6);
    ticks(3); chk_time("R10 two prior updates jump", 8'd3, 8'd0, 8'd0);

    // R9 fall back once
    load(8'h0E, 8'd1, 8'd59, 8'd50, 8'd1, 8'd22, 8'd10, 8'd6);
    ticks(10); chk_time("R9 not last Sunday", 8'd2, 8'd0, 8'd0);
    load(8'h0E, 8'd1, 8'd59, 8'd50, 8'd1, 8'd29, 8'd10, 8'd6);
    ticks(10); chk_time("R9 set back", 8'd1, 8'd0, 8'd0);
    ticks(3599); chk_time("R9 second pass reaches", 8'd1, 8'd59, 8'd59);
    ticks(1); chk_time("R9 only once", 8'd2, 8'd0, 8'd0);

    // R11 R12 wildcard alarm
    wreg(4'h8, 8'd5); wreg(4'h9, 8'hC0); wreg(4'hA, 8'hFF);
    load(8'h26, 8'd10, 8'd20, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0);
    for (int k = 1; k <= 150; k++) begin
      ticks(1);
      chk("R11 wildcard alarm", alm_pulse, 1'((k % 60) == 5));
      chk("R12 irq follows alarm", irq, 1'((k % 60) == 5));
    end
    wreg(4'hF, 8'h16);
    ticks(1);
    chk("R12 irq on update", irq, 1'b1);
    @(negedge clk);
    chk("R12 irq drops", irq, 1'b0);

    // R11 exact alarm
    wreg(4'h8, 8'd40); wreg(4'h9, 8'd22); wreg(4'hA, 8'd10);
    load(8'h26, 8'd10, 8'd22, 8'd30, 8'd1, 8'd1, 8'd1, 8'd0);
    for (int k = 1; k <= 20; k++) begin
      ticks(1);
      chk("R11 exact alarm", alm_pulse, 1'(k == 10));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule